// File: doc/BRIEF.md
# Unpacked Decimal Addition Adjust Unit

This block corrects the result of a binary addition of two unpacked BCD digits so that it becomes a valid decimal digit with a carry. It holds a 16-bit accumulator, split into an upper byte and a lower byte. It also holds two flags: a carry flag and a half-carry flag. The half-carry flag records a carry out of the low nibble.

Software or a sequencer first writes the accumulator and both flags through the load port. It then raises an adjust command for one cycle. The unit looks only at the lower byte and the half-carry flag, and it rewrites the accumulator and the flags in place on the next clock edge. The cycle after each adjust that is carried out, a one-cycle completion pulse is raised. The accumulator and the flags are always visible on the outputs.

Top module: `unpk_adjust`

## Requirements
- R1: A synchronous active-high reset clears both accumulator bytes, both flags and the completion pulse to zero.
- R2: When `load_en` is high at a clock edge, `acc_hi`, `acc_lo`, `flag_c` and `flag_h` take `load_hi`, `load_lo`, `load_c` and `load_h` at that edge.
- R3: An adjust takes the correcting path when bits [3:0] of the lower byte, read as unsigned, exceed 9, or when `flag_h` is 1. A nibble of exactly 9 with `flag_h` at 0 does not take the correcting path.
- R4: On the correcting path, the new lower byte has bits [7:4] at zero and bits [3:0] equal to (old bits [3:0] + 6) mod 16.
- R5: On the correcting path, the upper byte increments by one modulo 256, so 0xFF becomes 0x00. The wrap changes no flag.
- R6: On the correcting path, both `flag_c` and `flag_h` become 1.
- R7: On an adjust that does not take the correcting path, both flags become 0 and both accumulator bytes keep their values.
- R8: When `load_en` and `adj_valid` are high at the same edge, only the load takes effect, and no completion pulse follows.
- R9: `adj_done` is high for exactly the one cycle after each edge at which an adjust was carried out, and is low otherwise.
- R10: With neither `load_en` nor `adj_valid` high, the accumulator and the flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Write the accumulator and flags |
| load_hi | input | 8 | Value written to the upper byte |
| load_lo | input | 8 | Value written to the lower byte |
| load_c | input | 1 | Value written to the carry flag |
| load_h | input | 1 | Value written to the half-carry flag |
| adj_valid | input | 1 | Adjust command, one cycle per operation |
| adj_done | output | 1 | One-cycle pulse after an adjust is carried out |
| acc_hi | output | 8 | Upper accumulator byte |
| acc_lo | output | 8 | Lower accumulator byte |
| flag_c | output | 1 | Carry flag |
| flag_h | output | 1 | Half-carry flag |

## Verification
The adjust is tried first with low nibbles on both sides of the threshold: 9 against 10, and 15, with the half-carry flag both clear and set. This separates a wrong comparison from a missing half-carry term. Nibble 15 and a nonzero upper nibble show whether the nibble overflow is dropped and bits [7:4] are cleared. An upper byte of 0xFF shows whether the increment wraps. A load and an adjust in the same cycle, and back-to-back adjusts, show the priority and the pulse width. Random loads mixed with random adjust commands then cover chains of repeated adjusts on the same value.

// File: rtl/unpk_adj_pkg.sv
package unpk_adj_pkg;

    localparam int BYTE_W    = 8;
    localparam int DIGIT_W   = 4;
    localparam int DIGIT_MAX = 9;
    localparam int FIX_STEP  = 6;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
        logic              c;
        logic              h;
    } acc_state_t;

    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_LOAD   = 2'd1,
        OP_ADJUST = 2'd2
    } acc_op_t;

    function automatic acc_op_t pick_op(input logic ld, input logic adj);
        if (ld)       return OP_LOAD;
        else if (adj) return OP_ADJUST;
        else          return OP_HOLD;
    endfunction

endpackage

// File: rtl/unpk_adj_detect.sv
module unpk_adj_detect
    import unpk_adj_pkg::*;
#(
    parameter int W     = BYTE_W,
    parameter int DW    = DIGIT_W,
    parameter int LIMIT = DIGIT_MAX
) (
    input  logic [W-1:0] lo,
    input  logic         half_c,
    output logic         fix
);
    localparam logic [DW-1:0] LIMIT_V = DW'(LIMIT);

    logic [DW-1:0] nib;
    assign nib = lo[DW-1:0];
    assign fix = (nib > LIMIT_V) || half_c;
endmodule

// File: rtl/unpk_adj_calc.sv
module unpk_adj_calc
    import unpk_adj_pkg::*;
#(
    parameter int DW   = DIGIT_W,
    parameter int STEP = FIX_STEP
) (
    input  acc_state_t cur,
    input  logic       fix,
    output acc_state_t nxt
);
    localparam logic [DW-1:0] STEP_V = DW'(STEP);

    logic [DW-1:0] digit;
    assign digit = cur.lo[DW-1:0] + STEP_V;

    always_comb begin
        nxt = cur;
        if (fix) begin
            nxt.lo = '0;
            nxt.lo[DW-1:0] = digit;
            nxt.hi = cur.hi + 1'b1;
            nxt.c  = 1'b1;
            nxt.h  = 1'b1;
        end else begin
            nxt.c  = 1'b0;
            nxt.h  = 1'b0;
        end
    end
endmodule

// File: rtl/unpk_adj_state.sv
module unpk_adj_state
    import unpk_adj_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  acc_op_t    op,
    input  acc_state_t load_val,
    input  acc_state_t adj_val,
    output acc_state_t cur,
    output logic       done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= '0;
            done <= 1'b0;
        end else begin
            done <= (op == OP_ADJUST);
            case (op)
                OP_LOAD:   cur <= load_val;
                OP_ADJUST: cur <= adj_val;
                default:   cur <= cur;
            endcase
        end
    end
endmodule

// File: rtl/unpk_adjust.sv
module unpk_adjust
    import unpk_adj_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [BYTE_W-1:0] load_hi,
    input  logic [BYTE_W-1:0] load_lo,
    input  logic              load_c,
    input  logic              load_h,
    input  logic              adj_valid,
    output logic              adj_done,
    output logic [BYTE_W-1:0] acc_hi,
    output logic [BYTE_W-1:0] acc_lo,
    output logic              flag_c,
    output logic              flag_h
);
    acc_state_t cur, load_val, adj_val;
    acc_op_t    op;
    logic       fix;

    assign op       = pick_op(load_en, adj_valid);
    assign load_val = '{hi: load_hi, lo: load_lo, c: load_c, h: load_h};

    unpk_adj_detect u_detect (
        .lo     (cur.lo),
        .half_c (cur.h),
        .fix    (fix)
    );

    unpk_adj_calc u_calc (
        .cur (cur),
        .fix (fix),
        .nxt (adj_val)
    );

    unpk_adj_state u_state (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .load_val (load_val),
        .adj_val  (adj_val),
        .cur      (cur),
        .done     (adj_done)
    );

    assign acc_hi = cur.hi;
    assign acc_lo = cur.lo;
    assign flag_c = cur.c;
    assign flag_h = cur.h;
endmodule

// File: rtl/unpk_adjust_chk.sv
module unpk_adjust_chk (
    input logic       clk,
    input logic       rst,
    input logic       load_en,
    input logic [7:0] load_hi,
    input logic [7:0] load_lo,
    input logic       adj_valid,
    input logic       adj_done,
    input logic [7:0] acc_hi,
    input logic [7:0] acc_lo,
    input logic       flag_c,
    input logic       flag_h
);
    AST_LOAD_WRITES: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (acc_hi == $past(load_hi)) && (acc_lo == $past(load_lo))); // R2

    AST_HI_WRAPS: assert property (@(posedge clk) disable iff (rst)
        (adj_valid && !load_en && ((acc_lo[3:0] > 4'd9) || flag_h))
        |=> (acc_hi == $past(acc_hi) + 8'd1) && flag_c && flag_h); // R5

    AST_PLAIN_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (adj_valid && !load_en && (acc_lo[3:0] <= 4'd9) && !flag_h)
        |=> !flag_c && !flag_h && $stable(acc_lo) && $stable(acc_hi)); // R7

    AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (adj_valid && !load_en) |=> adj_done); // R9

    AST_LOAD_BLOCKS_DONE: assert property (@(posedge clk) disable iff (rst)
        load_en |=> !adj_done); // R8

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!adj_valid && !load_en)
        |=> $stable(acc_hi) && $stable(acc_lo) && $stable(flag_c) && $stable(flag_h) && !adj_done); // R10
endmodule

bind unpk_adjust unpk_adjust_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .load_en   (load_en),
    .load_hi   (load_hi),
    .load_lo   (load_lo),
    .adj_valid (adj_valid),
    .adj_done  (adj_done),
    .acc_hi    (acc_hi),
    .acc_lo    (acc_lo),
    .flag_c    (flag_c),
    .flag_h    (flag_h)
);

// File: tb/unpk_adjust_bench.sv
module unpk_adjust_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_en = 1'b0;
    logic [7:0] load_hi = '0;
    logic [7:0] load_lo = '0;
    logic       load_c = 1'b0;
    logic       load_h = 1'b0;
    logic       adj_valid = 1'b0;
    logic       adj_done;
    logic [7:0] acc_hi, acc_lo;
    logic       flag_c, flag_h;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_hi = '0, m_lo = '0;
    logic       m_c = 1'b0, m_h = 1'b0, m_done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    unpk_adjust u_unpk_adjust (
        .clk(clk), .rst(rst), .load_en(load_en), .load_hi(load_hi),
        .load_lo(load_lo), .load_c(load_c), .load_h(load_h),
        .adj_valid(adj_valid), .adj_done(adj_done), .acc_hi(acc_hi),
        .acc_lo(acc_lo), .flag_c(flag_c), .flag_h(flag_h)
    );

    function automatic logic needs_fix(input logic [7:0] lo, input logic h);
        return (lo[3:0] > 4'd9) || h;
    endfunction

    function automatic logic [7:0] fixed_lo(input logic [7:0] lo);
        logic [3:0] d;
        d = lo[3:0] + 4'd6;
        return {4'b0000, d};
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic cycle(input logic ld, input logic [7:0] lh, input logic [7:0] ll,
                         input logic lc, input logic lhf, input logic adj);
        string t_hi, t_lo, t_fl, t_dn;
        logic fx;
        @(negedge clk);
        load_en = ld; load_hi = lh; load_lo = ll; load_c = lc; load_h = lhf; adj_valid = adj;
        fx = needs_fix(m_lo, m_h);
        if (ld) begin
            t_hi = "R2"; t_lo = "R2"; t_fl = "R2"; t_dn = (adj ? "R8" : "R9");
            m_hi = lh; m_lo = ll; m_c = lc; m_h = lhf;
        end else if (adj) begin
            t_hi = fx ? "R5" : "R7"; t_lo = fx ? "R4" : "R7"; t_fl = fx ? "R6" : "R7"; t_dn = "R9";
            if (fx) begin
                m_hi = m_hi + 8'd1; m_lo = fixed_lo(m_lo); m_c = 1'b1; m_h = 1'b1;
            end else begin
                m_c = 1'b0; m_h = 1'b0;
            end
        end else begin
            t_hi = "R10"; t_lo = "R10"; t_fl = "R10"; t_dn = "R9";
        end
        m_done = adj && !ld;
        @(posedge clk);
        #1;
        chk(t_hi, "acc_hi", acc_hi, m_hi);
        chk(t_lo, "acc_lo", acc_lo, m_lo);
        chk(t_fl, "flag_c", flag_c, m_c);
        chk(t_fl, "flag_h", flag_h, m_h);
        chk(t_dn, "adj_done", adj_done, m_done);
    endtask

    task automatic ld_val(input logic [7:0] h, input logic [7:0] l, input logic c, input logic hf);
        cycle(1'b1, h, l, c, hf, 1'b0);
    endtask

    task automatic adjust();
        cycle(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic idle();
        cycle(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: the reset state
        load_en = 1'b1; load_hi = 8'hAA; load_lo = 8'h55; load_c = 1'b1; load_h = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0; load_en = 1'b0;
        #1;
        chk("R1", "acc_hi", acc_hi, 0);
        chk("R1", "acc_lo", acc_lo, 0);
        chk("R1", "flags", {flag_c, flag_h}, 0);
        chk("R1", "adj_done", adj_done, 0);

        // R3: the threshold boundary, nibble 9 against 10
        ld_val(8'h12, 8'h39, 1'b1, 1'b0);
        adjust();
        chk("R3", "nibble 9 no fix", flag_c, 0);
        ld_val(8'h12, 8'h3A, 1'b0, 1'b0);
        adjust();
        chk("R3", "nibble 10 fixes", flag_c, 1);
        chk("R4", "nibble 10 result", acc_lo, 8'h00);

        // R4: nibble 15 with upper bits set
        ld_val(8'h00, 8'hFF, 1'b0, 1'b0);
        adjust();
        chk("R4", "nibble 15 result", acc_lo, 8'h05);

        // R3: the half-carry flag alone triggers the correcting path
        ld_val(8'h07, 8'h32, 1'b0, 1'b1);
        adjust();
        chk("R3", "half-carry path lo", acc_lo, 8'h08);

        // R5: wrap of the upper byte
        ld_val(8'hFF, 8'h0C, 1'b0, 1'b0);
        adjust();
        chk("R5", "wrap hi", acc_hi, 0);

        // R9: back-to-back adjusts, then idle
        adjust();
        adjust();
        idle();
        chk("R9", "done after idle", adj_done, 0);

        // R8: a load and an adjust in the same cycle
        cycle(1'b1, 8'h44, 8'h0E, 1'b0, 1'b0, 1'b1);
        chk("R8", "load wins lo", acc_lo, 8'h0E);
        idle();

        for (int i = 0; i < 400; i++) begin
            logic [7:0] rl;
            rl = 8'($urandom);
            if ($urandom_range(0, 2) == 0) rl[3:0] = 4'($urandom_range(8, 11));
            cycle($urandom_range(0, 4) == 0, 8'($urandom), rl,
                  1'($urandom), ($urandom_range(0, 3) == 0), ($urandom_range(0, 1) == 1));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule